// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block sits between instruction issue and the memory port of an out-of-order core. Loads and stores are entered in program order into a small circular queue. Each entry later gets its effective address, formed from a base value and a sign-extended immediate. Addresses are filled in strictly in allocation order. A store also needs its write data. That data either comes with the allocation or arrives later on a result broadcast bus, where the store's tag selects it.

Each cycle the queue offers at most one memory request, and only while the memory port reports it is free. A request is sent only when comparing the entry's address with all older outstanding entries shows no ordering hazard:
- A load may pass older operations that touch other addresses.
- A store waits for every older operation that touches the same address.
- An entry with no address yet holds back itself and everything younger.

Among the entries that are eligible, the oldest one wins. Issued entries leave the queue from the head in program order.

Top module: `mem_order_queue`

## Requirements
- R1: After reset `req_valid_o` and `full_o` are 0.
- R2: An address update (`agen_valid_i`) writes `agen_base_i` plus the sign-extended `agen_imm_i` into the oldest entry that still lacks an address. It is ignored when no such entry exists.
- R3: An entry with no address is never issued, and neither is any entry younger than it.
- R4: A load (`req_write_o`=0) is not issued while an older, unissued store has the same address.
- R5: A store is not issued while an older, unissued load has the same address.
- R6: A store is not issued while an older, unissued store has the same address.
- R7: A load with an address may be issued ahead of older entries, loads or stores, whose addresses differ from its own.
- R8: A store (`req_write_o`=1) is issued only after it holds data. Data is taken at allocation when `alloc_data_valid_i`=1, or later from a bus cycle whose `bus_tag_i` equals the store's tag. A bus cycle with another tag leaves the store waiting.
- R9: `req_valid_o` is asserted only while `mem_ready_i`=1. Each asserted cycle issues one entry, and it is the oldest eligible one.
- R10: The queue holds DEPTH (8) entries. `full_o` is 1 when all are occupied, and an allocation while `full_o`=1 is dropped.
- R11: Issued entries are freed from the head in program order, and freed slots can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate a new entry at the tail |
| alloc_store_i | input | 1 | 1 = store, 0 = load |
| alloc_tag_i | input | TW | Tag used to match store data on the bus |
| alloc_data_valid_i | input | 1 | Store data is supplied with the allocation |
| alloc_data_i | input | DW | Store data supplied with the allocation |
| full_o | output | 1 | All entries occupied |
| agen_valid_i | input | 1 | Address update for the oldest entry without an address |
| agen_base_i | input | AW | Base value |
| agen_imm_i | input | IMMW | Immediate, sign-extended to AW |
| bus_valid_i | input | 1 | Result broadcast valid |
| bus_tag_i | input | TW | Result broadcast tag |
| bus_data_i | input | DW | Result broadcast value |
| mem_ready_i | input | 1 | Memory port can take a request this cycle |
| req_valid_o | output | 1 | Memory request issued this cycle |
| req_write_o | output | 1 | 1 = write (store), 0 = read (load) |
| req_addr_o | output | AW | Request address |
| req_wdata_o | output | DW | Write data, valid when req_write_o = 1 |

## Verification
The assertions rely on two properties of the inputs. Allocations arrive in program order. Each store's tag is unique among the outstanding stores, so one bus cycle completes at most one waiting store. The stimulus gives every store a distinct tag. It allocates only while `full_o` is low, except in the single step that deliberately tests a dropped allocation. Bus cycles are driven in separate cycles from allocations, and the memory port is held busy during setup, so the release order depends only on the hazard rules and on age.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;
  typedef struct packed {
    logic valid;
    logic store;
    logic aok;   // address present
    logic dok;   // store data present
    logic done;  // request issued
  } ent_flags_t;
endpackage

// File: rtl/mem_order_conflict.sv
module mem_order_conflict #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] vld_i,
  input  logic [DEPTH-1:0] str_i,
  input  logic [DEPTH-1:0] aok_i,
  input  logic [DEPTH-1:0] dok_i,
  input  logic [DEPTH-1:0] dne_i,
  input  logic [AW-1:0]    addr_i [DEPTH],
  input  logic [IW-1:0]    head_i,
  output logic [DEPTH-1:0] elig_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IW-1:0] age_i;
    logic          blk;
    assign age_i = IW'(i) - head_i;
    always_comb begin
      blk = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (vld_i[j] && ((IW'(j) - head_i) < age_i)) begin
          if (!aok_i[j]) blk = 1'b1;
          else if (!dne_i[j] && addr_i[j] == addr_i[i] && (str_i[i] || str_i[j]))
            blk = 1'b1;
        end
      end
    end
    assign elig_o[i] = vld_i[i] & ~dne_i[i] & aok_i[i] & (~str_i[i] | dok_i[i]) & ~blk;
  end
endmodule

// File: rtl/mem_order_pick.sv
module mem_order_pick #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig_i,
  input  logic [IW-1:0]    head_i,
  output logic             found_o,
  output logic [IW-1:0]    sel_o
);
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    // scan youngest to oldest so the oldest hit is kept
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (elig_i[head_i + IW'(k)]) begin
        found_o = 1'b1;
        sel_o   = head_i + IW'(k);
      end
    end
  end
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mem_order_pkg::*;
#(
  parameter int DEPTH = 8,   // power of two
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 6,
  parameter int IMMW  = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_valid_i,
  input  logic            alloc_store_i,
  input  logic [TW-1:0]   alloc_tag_i,
  input  logic            alloc_data_valid_i,
  input  logic [DW-1:0]   alloc_data_i,
  output logic            full_o,
  input  logic            agen_valid_i,
  input  logic [AW-1:0]   agen_base_i,
  input  logic [IMMW-1:0] agen_imm_i,
  input  logic            bus_valid_i,
  input  logic [TW-1:0]   bus_tag_i,
  input  logic [DW-1:0]   bus_data_i,
  input  logic            mem_ready_i,
  output logic            req_valid_o,
  output logic            req_write_o,
  output logic [AW-1:0]   req_addr_o,
  output logic [DW-1:0]   req_wdata_o
);
  ent_flags_t       flg_q  [DEPTH];
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [TW-1:0]    tag_q  [DEPTH];
  logic [IW-1:0]    head_q, tail_q, aptr_q;

  logic [DEPTH-1:0] vld_v, str_v, aok_v, dok_v, dne_v, elig;
  logic             found, alloc_fire, agen_fire, retire, issue;
  logic [IW-1:0]    sel;
  logic [AW-1:0]    eff_addr;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_v[i] = flg_q[i].valid;
      str_v[i] = flg_q[i].store;
      aok_v[i] = flg_q[i].aok;
      dok_v[i] = flg_q[i].dok;
      dne_v[i] = flg_q[i].done;
    end
  end

  mem_order_conflict #(.DEPTH(DEPTH), .AW(AW)) i_conflict (
    .vld_i (vld_v), .str_i (str_v), .aok_i (aok_v), .dok_i (dok_v), .dne_i (dne_v),
    .addr_i(addr_q), .head_i(head_q), .elig_o(elig)
  );

  mem_order_pick #(.DEPTH(DEPTH)) i_pick (
    .elig_i(elig), .head_i(head_q), .found_o(found), .sel_o(sel)
  );

  assign eff_addr   = agen_base_i + {{(AW-IMMW){agen_imm_i[IMMW-1]}}, agen_imm_i};
  assign full_o     = flg_q[tail_q].valid;
  assign alloc_fire = alloc_valid_i & ~flg_q[tail_q].valid;
  assign agen_fire  = agen_valid_i & flg_q[aptr_q].valid & ~flg_q[aptr_q].aok;
  assign retire     = flg_q[head_q].valid & flg_q[head_q].done;
  assign issue      = found & mem_ready_i;

  assign req_valid_o = issue;
  assign req_write_o = flg_q[sel].store;
  assign req_addr_o  = addr_q[sel];
  assign req_wdata_o = data_q[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      aptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        flg_q[i]  <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (bus_valid_i && flg_q[i].valid && flg_q[i].store && !flg_q[i].dok
            && tag_q[i] == bus_tag_i) begin
          flg_q[i].dok <= 1'b1;
          data_q[i]    <= bus_data_i;
        end
      end
      if (issue) flg_q[sel].done <= 1'b1;
      if (agen_fire) begin
        flg_q[aptr_q].aok <= 1'b1;
        addr_q[aptr_q]    <= eff_addr;
        aptr_q            <= aptr_q + 1'b1;
      end
      if (retire) begin
        flg_q[head_q] <= '0;
        head_q        <= head_q + 1'b1;
      end
      if (alloc_fire) begin
        flg_q[tail_q] <= '{valid: 1'b1, store: alloc_store_i, aok: 1'b0,
                           dok: alloc_store_i & alloc_data_valid_i, done: 1'b0};
        data_q[tail_q] <= alloc_data_i;
        tag_q[tail_q]  <= alloc_tag_i;
        tail_q         <= tail_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_order_chk.sv
module mem_order_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic             req_write_o,
  input logic             mem_ready_i,
  input logic             full_o,
  input logic [IW-1:0]    sel,
  input logic [IW-1:0]    head_q,
  input logic [DEPTH-1:0] vld_v,
  input logic [DEPTH-1:0] str_v,
  input logic [DEPTH-1:0] aok_v,
  input logic [DEPTH-1:0] dok_v,
  input logic [DEPTH-1:0] dne_v,
  input logic [AW-1:0]    addr_q [DEPTH]
);
  logic          hazard, unaddr_older;
  logic [IW-1:0] sel_age, sel_q;

  assign sel_age = sel - head_q;
  always_comb begin
    hazard       = 1'b0;
    unaddr_older = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (vld_v[j] && ((IW'(j) - head_q) < sel_age)) begin
        if (!aok_v[j]) unaddr_older = 1'b1;
        else if (!dne_v[j] && addr_q[j] == addr_q[sel] && (req_write_o || str_v[j]))
          hazard = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel;

  // R9
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> mem_ready_i);
  // R3
  addr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (aok_v[sel] && !unaddr_older));
  // R4
  raw_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_write_o) |-> !hazard);
  // R6
  ww_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_write_o) |-> !hazard);
  // R8
  wdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_write_o) |-> dok_v[sel]);
  // R10
  full_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> ($countones(vld_v) == DEPTH));
  // R11
  issued_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> (vld_v[sel_q] && dne_v[sel_q]));
endmodule

bind mem_order_queue mem_order_chk #(.DEPTH(DEPTH), .AW(AW)) i_mem_order_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_o(req_valid_o), .req_write_o(req_write_o),
  .mem_ready_i(mem_ready_i), .full_o(full_o), .sel(sel), .head_q(head_q),
  .vld_v(vld_v), .str_v(str_v), .aok_v(aok_v), .dok_v(dok_v), .dne_v(dne_v),
  .addr_q(addr_q)
);

// File: tb/test_mem_order_queue.sv
module test_mem_order_queue;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        alloc_valid_i = 0, alloc_store_i = 0, alloc_data_valid_i = 0;
  logic [5:0]  alloc_tag_i = '0, bus_tag_i = '0;
  logic [31:0] alloc_data_i = '0, agen_base_i = '0, bus_data_i = '0;
  logic [15:0] agen_imm_i = '0;
  logic        agen_valid_i = 0, bus_valid_i = 0, mem_ready_i = 0;
  logic        full_o, req_valid_o, req_write_o;
  logic [31:0] req_addr_o, req_wdata_o;

  int checks = 0, errors = 0, seen = 0;
  bit          exp_w[$];
  logic [31:0] exp_a[$], exp_d[$];
  string       exp_r[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_order_queue i_mem_order_queue (.*);

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk_i); #1; endtask

  task automatic alloc(bit st, logic [5:0] tag, bit dv, logic [31:0] d);
    alloc_valid_i = 1; alloc_store_i = st; alloc_tag_i = tag;
    alloc_data_valid_i = dv; alloc_data_i = d;
    step();
    alloc_valid_i = 0; alloc_data_valid_i = 0;
  endtask

  task automatic agen(logic [31:0] b, logic [15:0] imm);
    agen_valid_i = 1; agen_base_i = b; agen_imm_i = imm;
    step();
    agen_valid_i = 0;
  endtask

  task automatic bus(logic [5:0] t, logic [31:0] d);
    bus_valid_i = 1; bus_tag_i = t; bus_data_i = d;
    step();
    bus_valid_i = 0;
  endtask

  task automatic expect_req(bit w, logic [31:0] a, logic [31:0] d, string r);
    exp_w.push_back(w); exp_a.push_back(a); exp_d.push_back(d); exp_r.push_back(r);
  endtask

  task automatic idle(int n); repeat (n) step(); endtask

  task automatic drain();
    for (int n = 0; n < 100 && exp_w.size() > 0; n++) step();
    while (exp_w.size() > 0) begin
      chk(0, exp_r.pop_front(), "request never issued, addr", 32'hx, exp_a.pop_front());
      void'(exp_w.pop_front()); void'(exp_d.pop_front());
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare issued requests against the expected queue
  always @(negedge clk_i) begin
    if (rst_ni && req_valid_o) begin
      seen++;
      if (!mem_ready_i) chk(0, "R9", "request while port busy", 1, 0);
      if (exp_w.size() == 0) begin
        chk(0, "R9", "unexpected request addr", req_addr_o, 32'hx);
      end else begin
        automatic bit          w = exp_w.pop_front();
        automatic logic [31:0] a = exp_a.pop_front();
        automatic logic [31:0] d = exp_d.pop_front();
        automatic string       r = exp_r.pop_front();
        chk(req_write_o == w, r, "kind", 32'(req_write_o), 32'(w));
        chk(req_addr_o == a, r, "addr", req_addr_o, a);
        if (w) chk(req_wdata_o == d, r, "wdata", req_wdata_o, d);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    chk(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int s;
    #(CLK_PERIOD * 3 + 1);
    // R1 reset state
    chk(req_valid_o == 0, "R1", "req_valid_o in reset", 32'(req_valid_o), 0);
    chk(full_o == 0, "R1", "full_o in reset", 32'(full_o), 0);
    rst_ni = 1;
    step();
    chk(req_valid_o == 0 && full_o == 0, "R1", "idle after reset", 32'(req_valid_o), 0);

    // R3 unaddressed entries hold back everything
    mem_ready_i = 1;
    alloc(0, 6'd1, 0, '0);
    alloc(0, 6'd2, 0, '0);
    s = seen;
    idle(4);
    chk(seen == s, "R3", "requests without address", 32'(seen - s), 0);
    expect_req(0, 32'h0000_0010, '0, "R3");
    expect_req(0, 32'h0000_0020, '0, "R2");
    agen(32'h0000_0010, 16'h0000);
    agen(32'h0000_0030, 16'hFFF0);
    drain();

    // R7/R8 loads bypass a store lacking data; store data from allocation
    mem_ready_i = 0;
    alloc(0, 6'd10, 0, '0);
    alloc(1, 6'd11, 0, '0);
    alloc(0, 6'd12, 0, '0);
    alloc(1, 6'd13, 1, 32'h0000_0077);
    agen(32'h40, 16'h0);
    agen(32'h80, 16'h0);
    agen(32'hC0, 16'h0);
    agen(32'h110, 16'hFFF0);
    expect_req(0, 32'h40, '0, "R9");
    expect_req(0, 32'hC0, '0, "R7");
    expect_req(1, 32'h100, 32'h77, "R8");
    mem_ready_i = 1;
    drain();
    s = seen;
    bus(6'd40, 32'hDEAD);
    idle(3);
    chk(seen == s, "R8", "store issued on tag mismatch", 32'(seen - s), 0);
    expect_req(1, 32'h80, 32'h1234, "R8");
    bus(6'd11, 32'h1234);
    drain();

    // R4/R5/R6 same-address chain
    mem_ready_i = 0;
    alloc(1, 6'd20, 0, '0);
    alloc(0, 6'd21, 0, '0);
    alloc(1, 6'd22, 1, 32'hAAAA);
    alloc(0, 6'd23, 0, '0);
    agen(32'h1000, 16'h0010);
    agen(32'h1020, 16'hFFF0);
    agen(32'h1010, 16'h0000);
    agen(32'h2000, 16'h0000);
    expect_req(0, 32'h2000, '0, "R7");
    mem_ready_i = 1;
    drain();
    s = seen;
    idle(3);
    chk(seen == s, "R4", "load or store passed waiting store", 32'(seen - s), 0);
    expect_req(1, 32'h1010, 32'h5555, "R6");
    expect_req(0, 32'h1010, '0, "R4");
    expect_req(1, 32'h1010, 32'hAAAA, "R5");
    bus(6'd20, 32'h5555);
    drain();

    // R6 back-to-back stores, younger already has data
    mem_ready_i = 0;
    alloc(1, 6'd30, 0, '0);
    alloc(1, 6'd31, 1, 32'hBBBB);
    agen(32'h500, 16'h0);
    agen(32'h500, 16'h0);
    mem_ready_i = 1;
    s = seen;
    idle(3);
    chk(seen == s, "R6", "younger store passed older", 32'(seen - s), 0);
    expect_req(1, 32'h500, 32'hCCCC, "R6");
    expect_req(1, 32'h500, 32'hBBBB, "R6");
    bus(6'd30, 32'hCCCC);
    drain();
    idle(2);

    // R10/R11 fill, drop extra allocation, drain in order, wrap around
    mem_ready_i = 0;
    for (int k = 0; k < 8; k++) alloc(0, 6'(k), 0, '0);
    chk(full_o == 1, "R10", "full_o with 8 entries", 32'(full_o), 1);
    alloc(1, 6'd50, 1, 32'hFFFF);
    for (int k = 0; k < 9; k++) agen(32'h3000 + 32'(4 * k), 16'h0);
    for (int k = 0; k < 8; k++) expect_req(0, 32'h3000 + 32'(4 * k), '0, "R10");
    mem_ready_i = 1;
    drain();
    idle(4);
    chk(full_o == 0, "R11", "full_o after drain", 32'(full_o), 0);
    s = seen;
    idle(3);
    chk(seen == s, "R10", "dropped allocation issued", 32'(seen - s), 0);
    expect_req(0, 32'h44, '0, "R11");
    alloc(0, 6'd60, 0, '0);
    agen(32'h44, 16'h0);
    drain();
    expect_req(0, 32'h48, '0, "R2");
    agen(32'h99, 16'h0);
    alloc(0, 6'd61, 0, '0);
    agen(32'h48, 16'h0);
    drain();
    finish_run();
  end
endmodule